// File: doc/BRIEF.md
# I/O-Strobe Byte Capture Buffer

This block records bytes that an external CPU presents on its data bus during I/O cycles. Each falling edge of the CPU's I/O chip-select, brought into the local clock domain through a synchroniser, writes the sampled byte into a local ring of 256 slots. A local consumer takes bytes from the ring one at a time and gets an explicit "no data" answer when the ring is empty.

The producer software keeps a ring descriptor in its own memory. After every successful pop, the block asks a bus master for ownership of the CPU bus and writes its new consumer count one byte below a configured remote base address. The producer therefore always knows how far the consumer has read. Loading a nonzero base first copies the producer's input index, stored two bytes below the base, into the output index one byte below it. This discards any message bytes left over from before. A base of zero turns the remote mirroring off.

Top module: `io_strobe_capture`

## Requirements
- R1: Each falling edge of `io_cs_n` stores the byte on `io_data` in the next ring slot. Pops return bytes in capture order.
- R2: The ring has 256 slots. The write and read positions wrap from 255 to 0 without losing order.
- R3: A pop on an empty ring reports `pop_valid`=0 and `pop_data`=0. It changes no count and causes no bus request.
- R4: `pop_done` is high for exactly one cycle, one cycle after a pop is accepted. It carries `pop_valid`=1 and the byte when data was present.
- R5: A capture into a ring that holds 256 unread bytes overwrites the oldest byte and advances the consumer count by one. It also sets `overflow`, which stays set until reset.
- R6: A capture has priority over a pop in the same cycle. That pop is served one cycle later, so on an empty ring it returns the newly captured byte.
- R7: After a successful pop with a nonzero base, the block raises `bus_req` and waits for `bus_gnt`. It then issues one write to base−1 with the new consumer count (modulo 256), drops `bus_req`, and waits for `bus_gnt` to fall.
- R8: With a base of zero, pops cause no bus activity.
- R9: Loading a nonzero base reads address base−2 under bus ownership and writes the value read to base−1.
- R10: `ready` is low during any bus sequence and while a deferred pop is pending. A `pop_req` or `base_we` in a cycle without `ready` is ignored, and a `base_we` together with `pop_req` is ignored.
- R11: After reset, `ready`=1 and `bus_req`, `cmd_valid`, `pop_done` and `overflow` are 0.
- R12: A command stays valid, with stable address and direction, until `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| io_cs_n | input | 1 | Asynchronous I/O chip-select from the CPU, active low |
| io_data | input | DATA_W | CPU data bus |
| pop_req | input | 1 | Request to take one byte |
| base_we | input | 1 | Load `base_in` as the remote base |
| base_in | input | ADDR_W | Remote base address, 0 disables mirroring |
| ready | output | 1 | Pops and base loads are accepted |
| pop_done | output | 1 | Pop result strobe |
| pop_valid | output | 1 | Pop returned a byte |
| pop_data | output | DATA_W | Popped byte, 0 when invalid |
| overflow | output | 1 | Sticky overwrite flag |
| bus_req | output | 1 | Bus ownership request to the master |
| bus_gnt | input | 1 | Bus ownership granted |
| cmd_valid | output | 1 | Memory command pending |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | DATA_W | Write data |
| cmd_rdata | input | DATA_W | Read data, valid with `cmd_done` |
| cmd_done | input | 1 | Command completed |

## Verification
A chip-select fall driven just after clock edge P0 passes two synchroniser stages and is written at edge P3, so every capture is held for three edges before any pop that depends on it. An accepted pop shows `pop_done` at the first falling clock edge after its accepting edge, and the bench samples there. In the collision case the bench checks that `pop_done` is absent one edge later and present two edges later. Bus commands have no fixed latency because they wait on the grant, so expected writes and reads go into an ordered queue that the bus responder compares whenever a command completes, and leftover entries at the end count as failures.

// File: rtl/io_strobe_capture.sv
module io_strobe_capture #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 20,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_cs_n,
  input  logic [DATA_W-1:0] io_data,
  input  logic              pop_req,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  output logic              ready,
  output logic              pop_done,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              overflow,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] cmd_rdata,
  input  logic              cmd_done
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int FILL_W = PTR_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_REL} state_t;

  state_t              state;
  logic                do_copy;
  logic [SYNC_N-1:0]   cs_sync;
  logic                cs_last;
  logic [DATA_W-1:0]   d_sync [SYNC_N];
  logic [DATA_W-1:0]   ring [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [FILL_W-1:0]   fill;
  logic                pop_pend;
  logic [ADDR_W-1:0]   base_r;
  logic [DATA_W-1:0]   wval;

  wire cap_edge  = cs_last & ~cs_sync[SYNC_N-1];
  wire full      = fill == FILL_W'(DEPTH);
  wire pop_acc   = pop_req & ready;
  wire pop_take  = (pop_acc | pop_pend) & ~cap_edge;
  wire base_take = base_we & ready & ~pop_req;

  assign ready     = (state == S_IDLE) & ~pop_pend;
  assign bus_req   = (state == S_REQ) | (state == S_RD) | (state == S_WR);
  assign cmd_valid = (state == S_RD) | (state == S_WR);
  assign cmd_write = state == S_WR;
  assign cmd_addr  = (state == S_RD) ? base_r - ADDR_W'(2) : base_r - ADDR_W'(1);
  assign cmd_wdata = wval;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sync <= '1;
      cs_last <= 1'b1;
    end else begin
      cs_sync <= {cs_sync[SYNC_N-2:0], io_cs_n};
      cs_last <= cs_sync[SYNC_N-1];
    end

  always_ff @(posedge clk) begin
    d_sync[0] <= io_data;
    for (int i = 1; i < SYNC_N; i++) d_sync[i] <= d_sync[i-1];
    if (cap_edge) ring[wr_ptr] <= d_sync[SYNC_N-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fill      <= '0;
      overflow  <= 1'b0;
      pop_pend  <= 1'b0;
      pop_done  <= 1'b0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
      base_r    <= '0;
      wval      <= '0;
      do_copy   <= 1'b0;
      state     <= S_IDLE;
    end else begin
      pop_done <= 1'b0;
      pop_pend <= (pop_acc | pop_pend) & cap_edge;
      if (cap_edge) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (full) begin
          rd_ptr   <= rd_ptr + 1'b1;
          overflow <= 1'b1;
        end else begin
          fill <= fill + 1'b1;
        end
      end else if (pop_take) begin
        pop_done <= 1'b1;
        if (fill != '0) begin
          pop_valid <= 1'b1;
          pop_data  <= ring[rd_ptr];
          rd_ptr    <= rd_ptr + 1'b1;
          fill      <= fill - 1'b1;
          if (base_r != '0) begin
            wval    <= DATA_W'(rd_ptr + 1'b1);
            do_copy <= 1'b0;
            state   <= S_REQ;
          end
        end else begin
          pop_valid <= 1'b0;
          pop_data  <= '0;
        end
      end
      if (base_take) begin
        base_r <= base_in;
        if (base_in != '0) begin
          do_copy <= 1'b1;
          state   <= S_REQ;
        end
      end
      case (state)
        S_REQ: if (bus_gnt) state <= do_copy ? S_RD : S_WR;
        S_RD:  if (cmd_done) begin
                 wval  <= cmd_rdata;
                 state <= S_WR;
               end
        S_WR:  if (cmd_done) state <= S_REL;
        S_REL: if (!bus_gnt) state <= S_IDLE;
        default: ;
      endcase
    end
endmodule

// File: rtl/io_strobe_capture_props.sv
module io_strobe_capture_props #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              pop_done,
  input logic              pop_valid,
  input logic              overflow,
  input logic              bus_req,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_done
);
  assert_cmd_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> bus_req);

  assert_empty_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done && !pop_valid |-> !bus_req);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !bus_req && !cmd_valid);
endmodule

bind io_strobe_capture io_strobe_capture_props #(.ADDR_W(ADDR_W)) u_props (
  .clk(clk), .rst_n(rst_n), .ready(ready), .pop_done(pop_done),
  .pop_valid(pop_valid), .overflow(overflow), .bus_req(bus_req),
  .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
  .cmd_done(cmd_done)
);

// File: tb/io_strobe_capture_test.sv
module io_strobe_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_cs_n = 1'b1;
  logic [7:0]  io_data = '0;
  logic        pop_req = 1'b0;
  logic        base_we = 1'b0;
  logic [19:0] base_in = '0;
  logic        ready, pop_done, pop_valid, overflow;
  logic [7:0]  pop_data;
  logic        bus_req, cmd_valid, cmd_write;
  logic        bus_gnt = 1'b0;
  logic        cmd_done = 1'b0;
  logic [19:0] cmd_addr;
  logic [7:0]  cmd_wdata;
  logic [7:0]  cmd_rdata = '0;

  always #2 clk = ~clk;

  io_strobe_capture uut (.*);

  int checks = 0, errors = 0;
  logic [7:0]  model_q[$];
  logic [8:0]  exp_pop[$];
  logic [27:0] exp_wr[$];
  logic [7:0]  rmem [256];
  logic [19:0] base_m = '0;
  logic [19:0] exp_rd_addr = '0;
  int          rcount = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_cap(logic [7:0] b);
    if (model_q.size() == 256) begin
      void'(model_q.pop_front());
      rcount = (rcount + 1) % 256;
    end
    model_q.push_back(b);
  endtask

  task automatic model_pop();
    if (model_q.size() > 0) begin
      exp_pop.push_back({1'b1, model_q.pop_front()});
      rcount = (rcount + 1) % 256;
      if (base_m != 0) exp_wr.push_back({base_m - 20'd1, rcount[7:0]});
    end else begin
      exp_pop.push_back(9'h000);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic cap(logic [7:0] b);
    model_cap(b);
    @(posedge clk); #1 io_data = b; io_cs_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 io_cs_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic do_pop(bit stray);
    model_pop();
    @(posedge clk); #1 pop_req = 1'b1;
    wait_ready();
    @(posedge clk); #1 pop_req = 1'b0;
    if (stray) begin base_we = 1'b1; base_in = 20'h0ABCD; end
    @(negedge clk);
    chk(pop_done == 1'b1, "R4", "pop_done one cycle after accept", pop_done, 1);
    @(posedge clk); #1 base_we = 1'b0;
  endtask

  task automatic cap_with_pop(logic [7:0] b);
    wait_ready();
    model_cap(b);
    model_pop();
    @(posedge clk); #1 io_data = b; io_cs_n = 1'b0;
    @(posedge clk);
    @(posedge clk); #1 pop_req = 1'b1;
    @(posedge clk); #1 pop_req = 1'b0;
    @(negedge clk);
    chk(pop_done == 1'b0, "R6", "pop deferred behind capture", pop_done, 0);
    @(negedge clk);
    chk(pop_done == 1'b1, "R6", "deferred pop served", pop_done, 1);
    @(posedge clk); #1 io_cs_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic set_base(logic [19:0] v);
    wait_ready();
    base_m = v;
    if (v != 0) begin
      exp_rd_addr = v - 20'd2;
      exp_wr.push_back({v - 20'd1, rmem[exp_rd_addr[7:0]]});
    end
    @(posedge clk); #1 base_we = 1'b1; base_in = v;
    @(posedge clk); #1 base_we = 1'b0;
    wait_ready();
  endtask

  always @(negedge clk) begin : monitor
    logic [8:0] e;
    if (rst_n && pop_done) begin
      if (exp_pop.size() == 0) begin
        chk(1'b0, "R4", "unexpected pop result", {pop_valid, pop_data}, 0);
      end else begin
        e = exp_pop.pop_front();
        chk({pop_valid, pop_data} == e, e[8] ? "R1" : "R3", "pop result",
            {pop_valid, pop_data}, e);
      end
    end
  end

  always @(negedge clk) begin : responder
    logic [27:0] w;
    if (!rst_n) begin
      bus_gnt = 1'b0;
      cmd_done = 1'b0;
    end else begin
      bus_gnt = bus_req;
      if (cmd_valid && !cmd_done) begin
        cmd_done = 1'b1;
        if (cmd_write) begin
          rmem[cmd_addr[7:0]] = cmd_wdata;
          if (exp_wr.size() == 0) begin
            chk(1'b0, "R8", "unexpected remote write", {cmd_addr, cmd_wdata}, 0);
          end else begin
            w = exp_wr.pop_front();
            chk({cmd_addr, cmd_wdata} == w, "R7", "remote write addr/data",
                {cmd_addr, cmd_wdata}, w);
          end
        end else begin
          cmd_rdata = rmem[cmd_addr[7:0]];
          chk(cmd_addr == exp_rd_addr, "R9", "remote read address", cmd_addr, exp_rd_addr);
        end
      end else begin
        cmd_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog: cycles %0d expected below %0d", 150000, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rmem[i] = 8'(i * 3);
    rmem[8'h3E] = 8'h55;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R11", "ready after reset", ready, 1);
    chk(bus_req == 1'b0 && cmd_valid == 1'b0, "R11", "bus idle after reset",
        {bus_req, cmd_valid}, 0);
    chk(pop_done == 1'b0 && overflow == 1'b0, "R11", "flags after reset",
        {pop_done, overflow}, 0);

    do_pop(1'b0);
    cap(8'hA1); cap(8'hB2); cap(8'hC3);
    do_pop(1'b0); do_pop(1'b0); do_pop(1'b0); do_pop(1'b0);

    set_base(20'h01240);
    cap(8'h11); cap(8'h22);
    do_pop(1'b1);
    wait_ready();
    do_pop(1'b0);
    wait_ready();
    do_pop(1'b0);
    wait_ready();

    cap_with_pop(8'h5A);
    wait_ready();
    cap(8'h66);
    cap_with_pop(8'h77);
    wait_ready();
    do_pop(1'b0);
    wait_ready();

    set_base(20'h0);
    cap(8'h9C);
    do_pop(1'b0);

    for (int i = 0; i < 200; i++) cap(8'(i + 7));
    for (int i = 0; i < 200; i++) do_pop(1'b0);
    for (int i = 0; i < 100; i++) cap(8'(i * 5 + 1));
    for (int i = 0; i < 100; i++) do_pop(1'b0);
    @(negedge clk);
    chk(overflow == 1'b0, "R2", "no overflow after wrap", overflow, 0);

    set_base(20'h01240);
    for (int i = 0; i < 258; i++) cap(8'(i ^ 8'h3C));
    @(negedge clk);
    chk(overflow == 1'b1, "R5", "overflow after 258 captures", overflow, 1);
    for (int i = 0; i < 257; i++) begin
      do_pop(1'b0);
      wait_ready();
    end
    @(negedge clk);
    chk(overflow == 1'b1, "R5", "overflow sticky", overflow, 1);

    repeat (10) @(negedge clk);
    chk(exp_wr.size() == 0, "R7", "pending remote writes", exp_wr.size(), 0);
    chk(exp_pop.size() == 0, "R4", "pending pop results", exp_pop.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule